// File: doc/BRIEF.md
# Halfword Load Unit

This block executes one kind of instruction: a load of an unsigned 16-bit value into a 32-bit destination register. It recognises four encodings of that load. Each encoding takes its address offset from a different source and has its own rule for updating the base register. On accepting an instruction word, the block reads the base and offset operands through combinational register-file read ports. It computes the effective address and issues a two-byte read on a valid/ready memory request port. It then waits for the response and writes the zero-extended result to the destination register. For the two indexed forms, it writes the updated base back in the same cycle.

Base index 31 selects the stack pointer, which comes in on its own port, and arms an alignment check. A misaligned stack pointer and an unrecognised word each end the instruction with a one-cycle flag. In both cases no memory request and no register write are made. The block accepts a new instruction only while idle. It has no condition-flag outputs, so it cannot affect condition flags.

Top module: `hload_unit`

## Requirements
- R1: Register-offset form is bits[31:21]=01111000011 and bits[11:10]=10, with offset index in [20:16], extend code in [15:13], shift bit in [12], base index in [9:5] and target in [4:0]. Extend codes 010 (zero-extend low 32 bits), 110 (sign-extend low 32 bits), 011 and 111 (all 64 bits) are legal. Shift bit 1 doubles the extended value. The address is base plus this offset, and there is no base write.
- R2: Post-indexed form is bits[31:21]=01111000010 and bits[11:10]=01, with a signed 9-bit immediate in [20:12]. The address is the unmodified base, and base plus the sign-extended immediate is written back to the base index.
- R3: Pre-indexed form is bits[31:21]=01111000010 and bits[11:10]=11, with the same immediate. Base plus the immediate is both the address and the value written back.
- R4: Unsigned-offset form is bits[31:22]=0111100101, with a 12-bit immediate in [21:10]. The address is base plus twice the immediate, and there is no base write.
- R5: Base index 31 takes the base from `spValue`. A base write with index 31 targets the stack pointer.
- R6: When the base index is 31 and `spValue[3:0]` is nonzero, `alignFault` pulses for one cycle in the cycle after acceptance. No memory request and no register write follow.
- R7: A word matching no form, or a register-offset word with extend bit [14]=0, makes `undefFlag` pulse for one cycle in the cycle after acceptance. No request and no write follow. This flag takes priority over the alignment check.
- R8: In the cycle after an accepted legal instruction, `memReqValid` rises and stays high with a stable `memReqAddr` until `memReqReady`. The block then waits for `memRspValid`; a response outside that wait is ignored.
- R9: In the cycle after the response, `rtWrEn` pulses with `rtWrData` = {16'h0, response} and `rtWrIdx` = target. For the indexed forms, `baseWrEn` pulses in that same cycle.
- R10: `busy` is high from the cycle after acceptance until the cycle after the final write or flag. `instrValid` while busy is ignored.
- R11: While `rstN` is low, `busy`, `memReqValid`, `rtWrEn`, `baseWrEn`, `alignFault` and `undefFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word present; taken when idle |
| instrWord | input | 32 | Instruction word |
| busy | output | 1 | Instruction in progress |
| rnIdx | output | 5 | Base read index, from `instrWord` |
| rmIdx | output | 5 | Offset read index, from `instrWord` |
| baseRegData | input | 64 | Register value at `rnIdx` |
| offRegData | input | 64 | Register value at `rmIdx` |
| spValue | input | 64 | Stack pointer value |
| memReqValid | output | 1 | Two-byte read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Byte address of the read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 16 | Read data |
| rtWrEn | output | 1 | Target register write strobe |
| rtWrIdx | output | 5 | Target register index |
| rtWrData | output | 32 | Zero-extended load result |
| baseWrEn | output | 1 | Base register write strobe |
| baseWrIdx | output | 5 | Base index (31 = stack pointer) |
| baseWrData | output | 64 | Updated base value |
| alignFault | output | 1 | Stack pointer alignment fault pulse |
| undefFlag | output | 1 | Unrecognised instruction pulse |

## Verification
The assertions assume the register file returns `baseRegData` and `offRegData` in the same cycle as the indices, and assume that the memory side never drops a response. The bench drives a register file as a continuous lookup on the index outputs. Its memory responder answers every accepted request exactly once, after 0 to 2 idle cycles, and places junk on `memRspData` at all other times. `memReqReady` follows a pseudo-random pattern, so requests are both held and taken at once. Junk instruction words are driven with `instrValid` high while the block is busy.

// File: rtl/hload_pkg.sv
package hload_pkg;
  localparam int IDX_W  = 5;
  localparam int HALF_W = 16;
  localparam int RES_W  = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_WB,
    ST_FAULT
  } hloadState_t;

  typedef struct packed {
    logic capture;
    logic latchRsp;
  } hloadCtl_t;
endpackage

// File: rtl/hload_dp.sv
module hload_dp
  import hload_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hloadCtl_t         ctl,
  input  logic [31:0]       instrWord,
  input  logic [ADDR_W-1:0] baseRegData,
  input  logic [ADDR_W-1:0] offRegData,
  input  logic [ADDR_W-1:0] spValue,
  input  logic [HALF_W-1:0] memRspData,
  output logic [IDX_W-1:0]  rnIdx,
  output logic [IDX_W-1:0]  rmIdx,
  output logic              decUndef,
  output logic              decMisalign,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [IDX_W-1:0]  rtIdx,
  output logic [RES_W-1:0]  rtData,
  output logic              wbNeeded,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [ADDR_W-1:0] wbData
);
  localparam logic [IDX_W-1:0] SP_IDX = '1;
  localparam int LOW_W = 32;

  logic [10:0] opHigh;
  logic [1:0]  opLow;
  logic        isRegForm, isPostForm, isPreForm, isUimmForm;
  logic [2:0]  extCode;
  logic        shiftBit;
  logic [ADDR_W-1:0] baseVal, immSigned, immScaled, regExt, regOff, offset, sum;

  assign opHigh = instrWord[31:21];
  assign opLow  = instrWord[11:10];
  assign rnIdx  = instrWord[9:5];
  assign rmIdx  = instrWord[20:16];
  assign extCode  = instrWord[15:13];
  assign shiftBit = instrWord[12];

  assign isRegForm  = (opHigh == 11'b01111000011) && (opLow == 2'b10) && extCode[1];
  assign isPostForm = (opHigh == 11'b01111000010) && (opLow == 2'b01);
  assign isPreForm  = (opHigh == 11'b01111000010) && (opLow == 2'b11);
  assign isUimmForm = (instrWord[31:22] == 10'b0111100101);

  assign baseVal   = (rnIdx == SP_IDX) ? spValue : baseRegData;
  assign immSigned = {{(ADDR_W-9){instrWord[20]}}, instrWord[20:12]};
  assign immScaled = {{(ADDR_W-13){1'b0}}, instrWord[21:10], 1'b0};

  always_comb begin
    if (extCode[0]) regExt = offRegData;
    else regExt = {{(ADDR_W-LOW_W){extCode[2] & offRegData[LOW_W-1]}}, offRegData[LOW_W-1:0]};
  end

  assign regOff = shiftBit ? {regExt[ADDR_W-2:0], 1'b0} : regExt;

  always_comb begin
    if (isRegForm) offset = regOff;
    else if (isUimmForm) offset = immScaled;
    else offset = immSigned;
  end

  assign sum = baseVal + offset;

  assign decUndef    = !(isRegForm || isPostForm || isPreForm || isUimmForm);
  assign decMisalign = (rnIdx == SP_IDX) && (baseVal[ALIGN_BITS-1:0] != '0);

  logic [ADDR_W-1:0] addrQ, wbDataQ;
  logic [IDX_W-1:0]  rtQ, rnQ;
  logic              wbQ;
  logic [HALF_W-1:0] rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wbDataQ <= '0;
      rtQ     <= '0;
      rnQ     <= '0;
      wbQ     <= 1'b0;
    end else if (ctl.capture) begin
      addrQ   <= isPostForm ? baseVal : sum;
      wbDataQ <= sum;
      rtQ     <= instrWord[4:0];
      rnQ     <= rnIdx;
      wbQ     <= isPostForm || isPreForm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspQ <= '0;
    else if (ctl.latchRsp) rspQ <= memRspData;
  end

  assign reqAddr  = addrQ;
  assign rtIdx    = rtQ;
  assign rtData   = {{(RES_W-HALF_W){1'b0}}, rspQ};
  assign wbNeeded = wbQ;
  assign wbIdx    = rnQ;
  assign wbData   = wbDataQ;
endmodule

// File: rtl/hload_ctl.sv
module hload_ctl
  import hload_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instrValid,
  input  logic      decUndef,
  input  logic      decMisalign,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output hloadCtl_t ctl,
  output logic      busy,
  output logic      reqValid,
  output logic      wbPhase,
  output logic      alignFault,
  output logic      undefFlag
);
  hloadState_t state, stateNext;
  logic faultIsUndef;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (instrValid) stateNext = (decUndef || decMisalign) ? ST_FAULT : ST_REQ;
      ST_REQ:   if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_WB;
      ST_WB:    stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      faultIsUndef <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.capture) faultIsUndef <= decUndef;
    end
  end

  assign ctl.capture  = (state == ST_IDLE) && instrValid;
  assign ctl.latchRsp = (state == ST_WAIT) && memRspValid;
  assign busy       = (state != ST_IDLE);
  assign reqValid   = (state == ST_REQ);
  assign wbPhase    = (state == ST_WB);
  assign alignFault = (state == ST_FAULT) && !faultIsUndef;
  assign undefFlag  = (state == ST_FAULT) && faultIsUndef;
endmodule

// File: rtl/hload_unit.sv
module hload_unit
  import hload_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  output logic              busy,
  output logic [4:0]        rnIdx,
  output logic [4:0]        rmIdx,
  input  logic [ADDR_W-1:0] baseRegData,
  input  logic [ADDR_W-1:0] offRegData,
  input  logic [ADDR_W-1:0] spValue,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [15:0]       memRspData,
  output logic              rtWrEn,
  output logic [4:0]        rtWrIdx,
  output logic [31:0]       rtWrData,
  output logic              baseWrEn,
  output logic [4:0]        baseWrIdx,
  output logic [ADDR_W-1:0] baseWrData,
  output logic              alignFault,
  output logic              undefFlag
);
  hloadCtl_t ctl;
  logic decUndef, decMisalign, wbPhase, wbNeeded;

  hload_ctl u_ctl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .decUndef(decUndef), .decMisalign(decMisalign),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .ctl(ctl), .busy(busy), .reqValid(memReqValid), .wbPhase(wbPhase),
    .alignFault(alignFault), .undefFlag(undefFlag)
  );

  hload_dp #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .instrWord(instrWord),
    .baseRegData(baseRegData), .offRegData(offRegData), .spValue(spValue),
    .memRspData(memRspData), .rnIdx(rnIdx), .rmIdx(rmIdx),
    .decUndef(decUndef), .decMisalign(decMisalign), .reqAddr(memReqAddr),
    .rtIdx(rtWrIdx), .rtData(rtWrData), .wbNeeded(wbNeeded),
    .wbIdx(baseWrIdx), .wbData(baseWrData)
  );

  assign rtWrEn   = wbPhase;
  assign baseWrEn = wbPhase && wbNeeded;
endmodule

// File: rtl/hload_chk.sv
module hload_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              rtWrEn,
  input logic [31:0]       rtWrData,
  input logic              baseWrEn,
  input logic              alignFault,
  input logic              undefFlag
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rtWrEn |-> (rtWrData[31:16] == 16'h0));

  assert_write_after_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtWrEn) |-> $past(memRspValid));

  assert_base_with_rt_R2: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> rtWrEn);

  assert_align_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (!memReqValid && !rtWrEn && !baseWrEn));

  assert_align_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |=> !alignFault);

  assert_undef_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> (!memReqValid && !rtWrEn && !baseWrEn && !alignFault));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({alignFault, undefFlag, memReqValid, rtWrEn}));

  assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rtWrEn || alignFault || undefFlag) |-> busy);
endmodule

bind hload_unit hload_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
  .rtWrEn(rtWrEn), .rtWrData(rtWrData), .baseWrEn(baseWrEn),
  .alignFault(alignFault), .undefFlag(undefFlag)
);

// File: tb/hload_unit_bench.sv
module hload_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic busy, memReqValid, rtWrEn, baseWrEn, alignFault, undefFlag;
  logic [4:0] rnIdx, rmIdx, rtWrIdx, baseWrIdx;
  logic [63:0] baseRegData, offRegData, memReqAddr, baseWrData;
  logic [63:0] spValue = '0;
  logic memReqReady = 1'b0;
  logic memRspValid = 1'b0;
  logic [15:0] memRspData = '0;
  logic [31:0] rtWrData;
  logic [63:0] gprs [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign baseRegData = gprs[rnIdx];
  assign offRegData  = gprs[rmIdx];

  hload_unit u_hload_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .busy(busy), .rnIdx(rnIdx), .rmIdx(rmIdx), .baseRegData(baseRegData),
    .offRegData(offRegData), .spValue(spValue), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .rtWrEn(rtWrEn), .rtWrIdx(rtWrIdx), .rtWrData(rtWrData),
    .baseWrEn(baseWrEn), .baseWrIdx(baseWrIdx), .baseWrData(baseWrData),
    .alignFault(alignFault), .undefFlag(undefFlag)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] memData(input logic [63:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  // Instruction builders (field layouts of R1..R4)
  function automatic logic [31:0] encReg(input logic [4:0] rt, rn, rm, input logic [2:0] ext, input logic s);
    return {11'b01111000011, rm, ext, s, 2'b10, rn, rt};
  endfunction
  function automatic logic [31:0] encPost(input logic [4:0] rt, rn, input logic [8:0] imm);
    return {11'b01111000010, imm, 2'b01, rn, rt};
  endfunction
  function automatic logic [31:0] encPre(input logic [4:0] rt, rn, input logic [8:0] imm);
    return {11'b01111000010, imm, 2'b11, rn, rt};
  endfunction
  function automatic logic [31:0] encUimm(input logic [4:0] rt, rn, input logic [11:0] imm);
    return {10'b0111100101, imm, rn, rt};
  endfunction

  // Behavioural reference model
  int ph = 0;            // 0 idle, 1 request, 2 wait, 3 write, 4 flag
  bit eUndef, eWb;
  logic [63:0] eAddr, eWbData;
  logic [4:0] eRt, eRn;
  logic [15:0] eData;
  string eTag;
  bit pend = 0;
  int dly = 0;
  logic [63:0] pAddr;
  logic [15:0] lfsr = 16'hACE1;

  task automatic predict(input logic [31:0] w);
    logic [63:0] base, off;
    int form;   // 0 undef, 1 reg, 2 post, 3 pre, 4 uimm
    form = 0;
    casez (w)
      32'b01111000011_?????_?1?_?_10_?????_?????: form = 1;
      32'b01111000010_?????????_01_?????_?????:  form = 2;
      32'b01111000010_?????????_11_?????_?????:  form = 3;
      32'b0111100101_????????????_?????_?????:   form = 4;
      default: form = 0;
    endcase
    base = (w[9:5] == 5'd31) ? spValue : gprs[w[9:5]];
    off = 64'(signed'(w[20:12]));
    if (form == 1) begin
      off = gprs[w[20:16]];
      if (w[15:13] == 3'b010) off = {32'h0, off[31:0]};
      else if (w[15:13] == 3'b110) off = {{32{off[31]}}, off[31:0]};
      if (w[12]) off = off * 2;
    end else if (form == 4) begin
      off = 64'(w[21:10]) * 2;
    end
    eRt = w[4:0];
    eRn = w[9:5];
    eWb = (form == 2 || form == 3);
    eWbData = base + off;
    eAddr = (form == 2) ? base : base + off;
    eTag = (form == 1) ? "R1" : (form == 2) ? "R2" : (form == 3) ? "R3" : "R4";
    if (eRn == 5'd31) eTag = {eTag, "/R5"};
    eUndef = (form == 0);
    if (form == 0) ph = 4;
    else if (eRn == 5'd31 && base[3:0] != 4'h0) ph = 4;
    else ph = 1;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0;
      pend = 0;
    end else begin
      if (memRspValid) pend = 0;
      else if (pend && dly > 0) dly--;
      if (ph == 1 && memReqReady) begin
        pend = 1;
        dly = int'(lfsr[1:0]) % 3;
        pAddr = eAddr;
      end
      case (ph)
        0: if (instrValid) predict(instrWord);
        1: if (memReqReady) ph = 2;
        2: if (memRspValid) begin eData = memRspData; ph = 3; end
        default: ph = 0;
      endcase
    end
  end

  // Compare every cycle, then drive the memory side
  always @(negedge clk) begin
    if (!rstN) begin
      chk("R11", "busy", 64'(busy), 0);
      chk("R11", "memReqValid", 64'(memReqValid), 0);
      chk("R11", "rtWrEn", 64'(rtWrEn), 0);
      chk("R11", "baseWrEn", 64'(baseWrEn), 0);
      chk("R11", "alignFault", 64'(alignFault), 0);
      chk("R11", "undefFlag", 64'(undefFlag), 0);
    end else begin
      chk("R10", "busy", 64'(busy), 64'(ph != 0));
      chk("R8", "memReqValid", 64'(memReqValid), 64'(ph == 1));
      if (ph == 1) chk(eTag, "memReqAddr", memReqAddr, eAddr);
      chk("R9", "rtWrEn", 64'(rtWrEn), 64'(ph == 3));
      if (ph == 3) begin
        chk("R9", "rtWrData", 64'(rtWrData), {48'h0, eData});
        chk("R9", "rtWrIdx", 64'(rtWrIdx), 64'(eRt));
      end
      chk(eTag, "baseWrEn", 64'(baseWrEn), 64'(ph == 3 && eWb));
      if (ph == 3 && eWb) begin
        chk(eTag, "baseWrData", baseWrData, eWbData);
        chk(eTag, "baseWrIdx", 64'(baseWrIdx), 64'(eRn));
      end
      chk("R6", "alignFault", 64'(alignFault), 64'(ph == 4 && !eUndef));
      chk("R7", "undefFlag", 64'(undefFlag), 64'(ph == 4 && eUndef));
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReqReady = lfsr[3] | lfsr[7];
    memRspValid = pend && dly == 0;
    memRspData = memRspValid ? memData(pAddr) : lfsr;   // junk outside a response (R8)
  end

  bit noiseOn = 0;

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    while (ph != 0) @(negedge clk);
    instrWord = w;
    instrValid = 1'b1;
    @(negedge clk);
    while (ph != 0) begin
      instrValid = noiseOn;            // ignored while busy (R10)
      instrWord = $urandom;
      @(negedge clk);
    end
    instrValid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) gprs[i] = 64'h0123_4567_0000_0000 + 64'(i) * 64'h0000_0000_0101_0110;
    gprs[31] = '0;
    gprs[2]  = 64'hFFFF_FFFF_8000_0024;
    gprs[4]  = 64'h0000_0001_FFFF_FFF0;
    spValue  = 64'h0000_7FFF_FFFF_FF00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: each extend code, with and without shift
    issue(encReg(5'd3, 5'd1, 5'd2, 3'b010, 1'b0));
    issue(encReg(5'd3, 5'd1, 5'd2, 3'b110, 1'b1));
    issue(encReg(5'd7, 5'd5, 5'd4, 3'b011, 1'b1));
    issue(encReg(5'd8, 5'd6, 5'd2, 3'b111, 1'b0));
    // R7: illegal extend code, unknown word
    issue(encReg(5'd3, 5'd1, 5'd2, 3'b000, 1'b0));
    issue(32'hDEAD_BEEF);
    // R2, R3: negative and positive immediates
    issue(encPost(5'd9, 5'd5, 9'h1F0));
    issue(encPre(5'd10, 5'd6, 9'h0FF));
    // R4: largest and zero immediate
    issue(encUimm(5'd11, 5'd7, 12'hFFF));
    issue(encUimm(5'd12, 5'd8, 12'h000));
    // R5: aligned stack pointer, writeback to 31
    issue(encPre(5'd1, 5'd31, 9'h1F0));
    // R6: misaligned stack pointer
    spValue = 64'h0000_7FFF_FFFF_FF08;
    issue(encUimm(5'd1, 5'd31, 12'h004));
    // R7 priority over alignment
    issue({11'b01111000010, 9'h0, 2'b00, 5'd31, 5'd2});
    spValue = 64'h0000_0000_0010_0000;
    // R10: junk instructions during busy cycles
    noiseOn = 1;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] w;
      case ($urandom % 5)
        0: w = encReg(5'($urandom), 5'($urandom), 5'($urandom), 3'($urandom), 1'($urandom));
        1: w = encPost(5'($urandom), 5'($urandom), 9'($urandom));
        2: w = encPre(5'($urandom), 5'($urandom), 9'($urandom));
        3: w = encUimm(5'($urandom), 5'($urandom), 12'($urandom));
        default: w = $urandom;
      endcase
      if (k % 7 == 3) spValue = 64'($urandom) << 2;
      issue(w);
    end
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule